// File: doc/BRIEF.md
# Automatic Level Control with Noise Gate

This block steers the gain code of a programmable-gain amplifier so that the recorded level stays close to a chosen target. Once per sample strobe it compares a measured input level with a target and with a noise-gate threshold. It then decides whether the gain code should fall (attack), rise (recovery) or stay where it is. Each strobe moves the gain by at most one step, and a per-direction step interval sets the pace.

A noise gate takes over when the input has stayed quiet for a fixed hold period. Depending on the gate mode, the gain then drops straight to the lowest code, fades there at a slow fixed pace, or is frozen. The gate lets go only when the input rises clearly above the level that engaged it. When the control loop is switched off, a manually supplied gain code is approached at one of four slew rates.

The level input is an attenuation below full scale in 0.5 dB units, so a larger number means a quieter signal. All durations are counted in sample strobes derived from the `SAMPLE_HZ` parameter.

Top module: `agc_level_ctrl`

## Requirements
- R1: After reset the gain output equals `GAIN_RESET` (default 16) and the gate flag is low.
- R2: The gain changes only on a cycle with `smp_stb` high, by at most one code per strobe, and never leaves 0..2^GAIN_W-1. A move that would pass a limit is skipped.
- R3: With the loop on and the gate open, a level louder than the target (`lvl_att < 57 - 3*tgt_code`, i.e. -28.5 dB plus 1.5 dB per code) lowers the gain by one code after every `(6 ms × 2^atk_code)` worth of consecutive strobes. The first step comes on the last strobe of the first interval.
- R4: With the loop on and the gate open, a level more than 1.5 dB quieter than the target (`lvl_att > target + 3`) raises the gain one code every `DECAY_MS` worth of strobes. Levels from the target to target+3 leave the gain unchanged.
- R5: The gate engages on the strobe that completes `GATE_MS` (250 ms) of consecutive strobes with the level strictly quieter than the threshold (`lvl_att > 153 - 3*thr_code`, i.e. -76.5 dB plus 1.5 dB per code). Any strobe at or above the threshold restarts the count. `gate_mode` 2'b00 never engages.
- R6: An engaged gate releases on the first strobe with `lvl_att + HYST_HDB < threshold` (default 6 dB louder than the threshold). Levels between that point and the threshold keep it engaged.
- R7: While engaged, `gate_mode` 2'b10 lowers the gain one code every `max(1, FADE strobes / 2^GAIN_W-1)` strobes (about 100 ms for a full ramp) and then holds it at 0 with the flag still high. Mode 2'b01 lowers it one code per strobe. Mode 2'b11 freezes it.
- R8: With `loop_en` low the gate flag clears on the next strobe, and the gain walks toward `man_gain` one code per `(SLEW_BASE_MS × 2^slew_code)` worth of strobes. A change of direction restarts the interval.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| smp_stb | input | 1 | One-cycle sample-rate strobe |
| loop_en | input | 1 | 1: automatic control, 0: manual slew |
| lvl_att | input | LVL_W | Input level, attenuation below full scale in 0.5 dB units |
| tgt_code | input | 4 | Target level code |
| atk_code | input | 4 | Attack interval code |
| thr_code | input | 5 | Gate threshold code |
| gate_mode | input | 2 | 00 off, 01 drop, 10 fade, 11 freeze |
| slew_code | input | 2 | Manual slew interval code |
| man_gain | input | GAIN_W | Manually requested gain code |
| gain | output | GAIN_W | Gain code to the amplifier |
| gate_on | output | 1 | Noise gate engaged |

## Verification
Gate engagement and a recovery gain step can land on the same strobe. The quiet signal that arms the gate is also quieter than the target, so the loop keeps stepping the gain upward throughout the hold period. The bench picks a recovery interval that divides the hold period exactly, so the strobe that engages the gate is also a recovery step. On that strobe it expects both the raised gain and the raised gate flag. It then expects the fade pacing to start counting afresh from the next strobe.

// File: rtl/agc_pkg.sv
`timescale 1ns/1ps
package agc_pkg;

   // Gain movement requested for the current strobe
   typedef enum logic [2:0] {
      MV_NONE,
      MV_ATK,
      MV_DECAY,
      MV_FADE,
      MV_SNAP,
      MV_UP,
      MV_DN
   } mv_e;

   localparam int TGT_TOP_HDB   = 57;   // -28.5 dB in half-dB attenuation
   localparam int THR_TOP_HDB   = 153;  // -76.5 dB in half-dB attenuation
   localparam int CODE_STEP_HDB = 3;    // 1.5 dB per code

   function automatic logic [9:0] tgt_hdb(input logic [3:0] code);
      return 10'(TGT_TOP_HDB) - 10'(code) * 10'(CODE_STEP_HDB);
   endfunction

   function automatic logic [9:0] thr_hdb(input logic [4:0] code);
      return 10'(THR_TOP_HDB) - 10'(code) * 10'(CODE_STEP_HDB);
   endfunction

   function automatic int ms_to_strobes(input int hz, input int ms);
      int v;
      v = (hz / 10) * ms / 100;
      return (v < 1) ? 1 : v;
   endfunction

   function automatic int max_of(input int a, input int b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/agc_gate_unit.sv
`timescale 1ns/1ps
module agc_gate_unit #(
   parameter int HOLD_N   = 12000,
   parameter int HYST_HDB = 12
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       stb,
   input  logic       enable,
   input  logic [9:0] lvl,
   input  logic [9:0] thr,
   output logic       gate_on
);
   localparam int CW = (HOLD_N < 2) ? 1 : $clog2(HOLD_N);

   logic [CW-1:0] run_q;
   logic          quiet;
   logic          loud;
   logic          run_done;

   assign quiet    = lvl > thr;
   assign loud     = (11'(lvl) + 11'(HYST_HDB)) < 11'(thr);
   assign run_done = (32'(run_q) == 32'(HOLD_N - 1));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         run_q   <= '0;
         gate_on <= 1'b0;
      end else if (stb) begin
         if (!enable) begin
            run_q   <= '0;
            gate_on <= 1'b0;
         end else if (gate_on) begin
            run_q <= '0;
            if (loud) gate_on <= 1'b0;
         end else if (quiet) begin
            if (run_done) begin
               gate_on <= 1'b1;
               run_q   <= '0;
            end else begin
               run_q <= run_q + 1'b1;
            end
         end else begin
            run_q <= '0;
         end
      end
   end
endmodule

// File: rtl/agc_step_pacer.sv
`timescale 1ns/1ps
module agc_step_pacer
   import agc_pkg::*;
#(
   parameter int CNT_W = 24
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             stb,
   input  mv_e              mv,
   input  logic [CNT_W-1:0] interval,
   output logic             step
);
   mv_e              prev_q;
   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] cnt_nxt;

   assign cnt_nxt = (mv == prev_q) ? cnt_q + 1'b1 : CNT_W'(1);
   assign step    = stb && (mv != MV_NONE) && (cnt_nxt >= interval);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         prev_q <= MV_NONE;
         cnt_q  <= '0;
      end else if (stb) begin
         prev_q <= mv;
         cnt_q  <= (mv == MV_NONE || step) ? '0 : cnt_nxt;
      end
   end
endmodule

// File: rtl/agc_level_ctrl.sv
`timescale 1ns/1ps
module agc_level_ctrl
   import agc_pkg::*;
#(
   parameter int GAIN_W       = 6,
   parameter int LVL_W        = 8,
   parameter int SAMPLE_HZ    = 48000,
   parameter int GATE_MS      = 250,
   parameter int FADE_MS      = 100,
   parameter int ATK_BASE_MS  = 6,
   parameter int DECAY_MS     = 24,
   parameter int SLEW_BASE_MS = 4,
   parameter int HYST_HDB     = 12,
   parameter int DEAD_HDB     = 3,
   parameter int GAIN_RESET   = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              smp_stb,
   input  logic              loop_en,
   input  logic [LVL_W-1:0]  lvl_att,
   input  logic [3:0]        tgt_code,
   input  logic [3:0]        atk_code,
   input  logic [4:0]        thr_code,
   input  logic [1:0]        gate_mode,
   input  logic [1:0]        slew_code,
   input  logic [GAIN_W-1:0] man_gain,
   output logic [GAIN_W-1:0] gain,
   output logic              gate_on
);
   localparam int GAIN_MAX   = (1 << GAIN_W) - 1;
   localparam int HOLD_N     = ms_to_strobes(SAMPLE_HZ, GATE_MS);
   localparam int FADE_TOTAL = ms_to_strobes(SAMPLE_HZ, FADE_MS);
   localparam int FADE_STEP  = max_of(1, FADE_TOTAL / GAIN_MAX);
   localparam int ATK_UNIT   = ms_to_strobes(SAMPLE_HZ, ATK_BASE_MS);
   localparam int DECAY_N    = ms_to_strobes(SAMPLE_HZ, DECAY_MS);
   localparam int SLEW_UNIT  = ms_to_strobes(SAMPLE_HZ, SLEW_BASE_MS);
   localparam int MAX_IV     = max_of(max_of(ATK_UNIT * 32768, SLEW_UNIT * 8),
                                      max_of(DECAY_N, FADE_STEP));
   localparam int CNT_W      = $clog2(MAX_IV + 1);

   // elaboration-time parameter checks
   generate
      if (GAIN_W < 2 || GAIN_W > 8) begin : g_bad_gain_w
         $error("GAIN_W must lie in 2..8");
      end
      if (LVL_W < 8 || LVL_W > 10) begin : g_bad_lvl_w
         $error("LVL_W must lie in 8..10");
      end
      if (GAIN_RESET < 0 || GAIN_RESET > GAIN_MAX) begin : g_bad_reset
         $error("GAIN_RESET outside the gain code range");
      end
      if (HYST_HDB < 1 || DEAD_HDB < 0) begin : g_bad_band
         $error("HYST_HDB must be positive and DEAD_HDB non-negative");
      end
   endgenerate

   logic [9:0]       lvl_x;
   logic [9:0]       tgt_x;
   logic [9:0]       thr_x;
   logic             at_min;
   logic             at_max;
   logic             gate_en;
   logic             step;
   mv_e              mv;
   logic [CNT_W-1:0] interval;

   assign lvl_x   = 10'(lvl_att);
   assign tgt_x   = tgt_hdb(tgt_code);
   assign thr_x   = thr_hdb(thr_code);
   assign at_min  = (gain == '0);
   assign at_max  = (gain == GAIN_W'(GAIN_MAX));
   assign gate_en = loop_en && (gate_mode != 2'b00);

   // movement decision
   always_comb begin
      mv = MV_NONE;
      if (!loop_en) begin
         if (man_gain > gain)      mv = MV_UP;
         else if (man_gain < gain) mv = MV_DN;
      end else if (gate_on) begin
         if (!at_min) begin
            case (gate_mode)
               2'b10:   mv = MV_FADE;
               2'b01:   mv = MV_SNAP;
               default: mv = MV_NONE;
            endcase
         end
      end else if (lvl_x < tgt_x) begin
         if (!at_min) mv = MV_ATK;
      end else if (11'(lvl_x) > 11'(tgt_x) + 11'(DEAD_HDB)) begin
         if (!at_max) mv = MV_DECAY;
      end
   end

   // strobes per step for the chosen movement
   always_comb begin
      case (mv)
         MV_ATK:        interval = CNT_W'(ATK_UNIT) << atk_code;
         MV_DECAY:      interval = CNT_W'(DECAY_N);
         MV_FADE:       interval = CNT_W'(FADE_STEP);
         MV_UP, MV_DN:  interval = CNT_W'(SLEW_UNIT) << slew_code;
         default:       interval = CNT_W'(1);
      endcase
   end

   agc_step_pacer #(.CNT_W(CNT_W)) u_pacer (
      .clk      (clk),
      .rst_n    (rst_n),
      .stb      (smp_stb),
      .mv       (mv),
      .interval (interval),
      .step     (step)
   );

   agc_gate_unit #(.HOLD_N(HOLD_N), .HYST_HDB(HYST_HDB)) u_gate (
      .clk     (clk),
      .rst_n   (rst_n),
      .stb     (smp_stb),
      .enable  (gate_en),
      .lvl     (lvl_x),
      .thr     (thr_x),
      .gate_on (gate_on)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         gain <= GAIN_W'(GAIN_RESET);
      end else if (step) begin
         case (mv)
            MV_DECAY, MV_UP:           gain <= gain + 1'b1;
            MV_ATK, MV_FADE, MV_SNAP,
            MV_DN:                     gain <= gain - 1'b1;
            default:                   gain <= gain;
         endcase
      end
   end
endmodule

// File: rtl/agc_level_ctrl_chk.sv
`timescale 1ns/1ps
module agc_level_ctrl_chk
   import agc_pkg::*;
#(
   parameter int GAIN_W   = 6,
   parameter int LVL_W    = 8,
   parameter int HYST_HDB = 12
) (
   input logic              clk,
   input logic              rst_n,
   input logic              smp_stb,
   input logic              loop_en,
   input logic [LVL_W-1:0]  lvl_att,
   input logic [4:0]        thr_code,
   input logic [1:0]        gate_mode,
   input logic [GAIN_W-1:0] gain,
   input logic              gate_on
);
   logic [10:0] thr_w;
   logic [10:0] lvl_w;
   assign thr_w = 11'(thr_hdb(thr_code));
   assign lvl_w = 11'(lvl_att);

   // R2
   gain_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !smp_stb |=> $stable(gain));

   // R2
   gain_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      smp_stb |=> (gain == $past(gain) ||
                   (GAIN_W+1)'(gain) == (GAIN_W+1)'($past(gain)) + 1'b1 ||
                   (GAIN_W+1)'(gain) + 1'b1 == (GAIN_W+1)'($past(gain))));

   // R5
   gate_arm_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (smp_stb && !gate_on && !(lvl_w > thr_w)) |=> !gate_on);

   // R6
   gate_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (smp_stb && gate_on && (lvl_w + 11'(HYST_HDB) < thr_w)) |=> !gate_on);

   // R7
   gate_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (smp_stb && loop_en && gate_on && gate_mode == 2'b11) |=> $stable(gain));

   // R8
   manual_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (smp_stb && !loop_en) |=> !gate_on);
endmodule

bind agc_level_ctrl agc_level_ctrl_chk #(
   .GAIN_W   (GAIN_W),
   .LVL_W    (LVL_W),
   .HYST_HDB (HYST_HDB)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .smp_stb   (smp_stb),
   .loop_en   (loop_en),
   .lvl_att   (lvl_att),
   .thr_code  (thr_code),
   .gate_mode (gate_mode),
   .gain      (gain),
   .gate_on   (gate_on)
);

// File: tb/tb_agc_level_ctrl.sv
`timescale 1ns/1ps
module tb_agc_level_ctrl;
   // small configuration: 2000 strobes per second
   localparam int HZ      = 2000;
   localparam int HOLD    = 500;  // 250 ms
   localparam int ATK_U   = 12;   // 6 ms
   localparam int DECAY   = 50;   // 25 ms
   localparam int SLEW_U  = 2;    // 1 ms
   localparam int FADE_ST = 3;    // 200 strobes / 63 codes

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       smp_stb = 1'b1;
   logic       loop_en = 1'b0;
   logic [7:0] lvl_att = 8'd57;
   logic [3:0] tgt_code = '0;
   logic [3:0] atk_code = '0;
   logic [4:0] thr_code = '0;
   logic [1:0] gate_mode = 2'b00;
   logic [1:0] slew_code = '0;
   logic [5:0] man_gain = 6'd16;
   logic [5:0] gain;
   logic       gate_on;

   int checks = 0;
   int errors = 0;

   always #2.5 clk = ~clk;

   agc_level_ctrl #(
      .GAIN_W(6), .LVL_W(8), .SAMPLE_HZ(HZ), .GATE_MS(250), .FADE_MS(100),
      .ATK_BASE_MS(6), .DECAY_MS(25), .SLEW_BASE_MS(1), .HYST_HDB(12),
      .DEAD_HDB(3), .GAIN_RESET(16)
   ) dut (
      .clk(clk), .rst_n(rst_n), .smp_stb(smp_stb), .loop_en(loop_en),
      .lvl_att(lvl_att), .tgt_code(tgt_code), .atk_code(atk_code),
      .thr_code(thr_code), .gate_mode(gate_mode), .slew_code(slew_code),
      .man_gain(man_gain), .gain(gain), .gate_on(gate_on)
   );

   task automatic chk(input string r, input int got, input int exp);
      checks++;
      if (got != exp) begin
         errors++;
         $display("FAIL %s: got %0d expected %0d", r, got, exp);
      end
   endtask

   task automatic run(input int n);
      repeat (n) @(posedge clk);
      #1;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      int g;
      int ta;
      int th;
      run(3);
      rst_n = 1'b1;
      chk("R1 gain", gain, 16);
      chk("R1 gate", gate_on, 0);
      run(5);
      chk("R1 gain held", gain, 16);

      // R8 manual slew sweep over all rates
      for (int s = 0; s < 4; s++) begin
         int iv;
         iv = SLEW_U << s;
         g = gain;
         slew_code = 2'(s);
         man_gain = 6'(g + 3);
         run(iv - 1);
         chk("R8 before step", gain, g);
         run(1);
         chk("R8 first step", gain, g + 1);
         run(2 * iv);
         chk("R8 reached", gain, g + 3);
         chk("R8 gate low", gate_on, 0);
      end
      slew_code = 2'd0;
      man_gain = 6'd25;
      run(1);
      chk("R8 reverse wait", gain, 28);
      run(1);
      chk("R8 reverse step", gain, 27);
      run(4);
      chk("R8 reverse done", gain, 25);

      // R2 no strobe, no change
      smp_stb = 1'b0;
      man_gain = 6'd40;
      run(20);
      chk("R2 no strobe", gain, 25);
      smp_stb = 1'b1;
      run(30);
      chk("R8 up to 40", gain, 40);

      // R3/R4 target code sweep
      loop_en = 1'b1;
      for (int t = 0; t < 16; t++) begin
         ta = 57 - 3 * t;
         tgt_code = 4'(t);
         g = gain;
         lvl_att = 8'(ta + 3);
         run(20);
         chk("R4 in band", gain, g);
         lvl_att = 8'(ta - 1);
         run(11);
         chk("R3 before attack", gain, g);
         run(1);
         chk("R3 attack step", gain, g - 1);
         lvl_att = 8'(ta);
         run(1);
      end

      // R3 attack interval sweep
      tgt_code = 4'd0;
      for (int a = 0; a < 4; a++) begin
         int iv;
         iv = ATK_U << a;
         atk_code = 4'(a);
         lvl_att = 8'd40;
         g = gain;
         run(iv - 1);
         chk("R3 attack wait", gain, g);
         run(1);
         chk("R3 attack code", gain, g - 1);
         lvl_att = 8'd57;
         run(1);
      end

      // R4 recovery
      lvl_att = 8'd61;
      run(DECAY - 1);
      chk("R4 decay wait", gain, 20);
      run(1);
      chk("R4 decay step", gain, 21);
      lvl_att = 8'd60;
      run(60);
      chk("R4 band edge", gain, 21);

      // R2 saturation at top
      loop_en = 1'b0;
      man_gain = 6'd63;
      run(100);
      chk("R8 to max", gain, 63);
      loop_en = 1'b1;
      lvl_att = 8'd61;
      run(60);
      chk("R2 saturate", gain, 63);

      // R5/R7 hold timer, restart, fade; engage coincides with a decay step
      loop_en = 1'b0;
      man_gain = 6'd16;
      run(100);
      chk("R8 back to 16", gain, 16);
      gate_mode = 2'b10;
      thr_code = 5'd0;
      loop_en = 1'b1;
      lvl_att = 8'd200;
      run(HOLD - 1);
      chk("R4 decay during hold", gain, 25);
      chk("R5 not yet", gate_on, 0);
      lvl_att = 8'd153;
      run(1);
      chk("R5 at threshold gain", gain, 26);
      chk("R5 restart", gate_on, 0);
      lvl_att = 8'd200;
      run(HOLD - 1);
      chk("R5 restarted wait gain", gain, 35);
      chk("R5 restarted wait", gate_on, 0);
      run(1);
      chk("R4 step on engage", gain, 36);
      chk("R5 engage", gate_on, 1);
      run(FADE_ST - 1);
      chk("R7 fade wait", gain, 36);
      run(1);
      chk("R7 fade step", gain, 35);
      run(FADE_ST * 35);
      chk("R7 fade floor", gain, 0);
      run(20);
      chk("R7 fade holds", gain, 0);
      chk("R7 flag kept", gate_on, 1);

      // R6 hysteresis
      lvl_att = 8'd141;
      run(10);
      chk("R6 inside band", gate_on, 1);
      lvl_att = 8'd140;
      run(1);
      chk("R6 release", gate_on, 0);

      // R5/R7 threshold sweep in freeze mode
      gate_mode = 2'b11;
      for (int c = 0; c < 32; c++) begin
         th = 153 - 3 * c;
         thr_code = 5'(c);
         lvl_att = 8'(th - 13);
         run(1);
         lvl_att = 8'(th);
         run(600);
         chk("R5 equal level", gate_on, 0);
         lvl_att = 8'(th + 1);
         run(HOLD - 1);
         chk("R5 sweep wait", gate_on, 0);
         run(1);
         chk("R5 sweep engage", gate_on, 1);
         g = gain;
         run(20);
         chk("R7 freeze", gain, g);
      end

      // R7 drop mode
      thr_code = 5'd0;
      lvl_att = 8'd140;
      run(1);
      gate_mode = 2'b01;
      lvl_att = 8'd154;
      run(HOLD);
      chk("R5 drop engage", gate_on, 1);
      g = gain;
      run(1);
      chk("R7 drop step", gain, (g > 0) ? g - 1 : 0);
      run(70);
      chk("R7 drop floor", gain, 0);

      // R5 gate off mode
      lvl_att = 8'd140;
      run(1);
      gate_mode = 2'b00;
      lvl_att = 8'd154;
      run(600);
      chk("R5 mode off", gate_on, 0);

      // R8 loop off clears gate
      gate_mode = 2'b01;
      run(HOLD);
      chk("R5 re-engage", gate_on, 1);
      loop_en = 1'b0;
      run(1);
      chk("R8 gate cleared", gate_on, 0);

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule